// File: doc/BRIEF.md
# Bandwidth-Throttled Memory Target

This block is a single-ported memory target with a request/response interface. A requester offers a request with `req_valid`, and the block takes it in any cycle where `req_accept` is high. Reads, acknowledged writes and posted writes all draw on one shared data-rate budget. Each accepted data request keeps the target busy for a short spell. The length of that spell is the request's byte count times a programmable cycles-per-byte factor. The throttle therefore limits the short-term rate of each request, not an average taken over many requests.

When a request is turned away, the block remembers this in one pending flag. Once the block can take work again, it sends a single-cycle `retry` pulse, and the requester knows it may offer the request again. Each accepted request that expects an answer gets a response after a programmable number of cycles. Responses pass through a four-entry in-order queue, and the consumer can stall that queue with `rsp_ready`.

Top module: `bw_mem_target`

## Requirements
- R1: `req_op` encodes 00 = read, 01 = write with acknowledge, 10 = posted write, 11 = command. Reads and both kinds of write draw on one shared throttle: any of them with equal size and factor blocks later requests for the same number of cycles.
- R2: An accepted data request of `req_size` bytes (1 to 64) with factor `cfg_cpb` makes the block busy for ceil(`req_size`·`cfg_cpb`/16) cycles. `cfg_cpb` is unsigned with 4 fractional bits. `req_accept` is low in exactly that many cycles right after the accepting cycle.
- R3: When that product rounds to zero (for example `cfg_cpb` = 0), the block does not become busy, and `req_accept` stays high in the next cycle.
- R4: A command request (11) gets a response with data zero and never starts or extends a busy period.
- R5: A request offered while the block is busy is refused and sets a pending flag. While the flag is set, every request is refused, even after the busy period has run out.
- R6: When the block is neither busy nor short of queue space and the pending flag is set, the flag clears. `retry` is then high for exactly one cycle, and `req_accept` is high in that same cycle.
- R7: `rsp_valid` first rises `cfg_lat` cycles after the accepting cycle; `cfg_lat` values below 2 count as 2. A read returns the last word written to `req_addr` (a word address), and a write acknowledge returns zero data. `rsp_op` echoes the request's code.
- R8: A posted write updates memory and produces no response.
- R9: At most 4 responses are outstanding, counting one still in flight. They leave in request order. While `rsp_ready` is low, the head response stays valid and unchanged. A request refused for lack of queue space also sets the pending flag and is answered by a retry once space frees up.
- R10: After reset, `req_accept` is high, `retry` and `rsp_valid` are low, and the block is neither busy nor pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_accept | output | 1 | Request taken in this cycle when valid |
| req_op | input | 2 | Request code (R1) |
| req_addr | input | ADDR_W | Word address |
| req_size | input | SIZE_W | Transfer size in bytes |
| req_wdata | input | DATA_W | Write data |
| cfg_cpb | input | CPB_W | Cycles per byte, 4 fractional bits |
| cfg_lat | input | LAT_W | Request-to-response latency in cycles |
| retry | output | 1 | One-cycle pulse: a refused request may be offered again |
| rsp_valid | output | 1 | Head response is due and presented |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_op | output | 2 | Code of the answered request |
| rsp_data | output | DATA_W | Read data, or zero for other codes |

## Verification
The throttle is exercised with integer factors, a fractional factor whose product needs rounding up, the smallest non-zero factor, the largest factor with the largest size, and a zero factor. Together these separate truncation from rounding up, and they show the idle case is not turned into a one-cycle stall. Reads, acknowledged writes, posted writes and commands are issued at the same factor to show they share one budget. The command case also shows that non-data requests are left out of it. A request held during a busy period shows the gap between the end of the busy period and the retry. A burst sent while `rsp_ready` is low fills the queue, which tests ordering, holding the head steady under backpressure, and retries caused by a full queue rather than by the throttle.

// File: rtl/bwm_pkg.sv
`timescale 1ns/1ps
package bwm_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_POST  = 2'b10,
    OP_CMD   = 2'b11
  } op_e;
endpackage

// File: rtl/bwm_throttle.sv
`timescale 1ns/1ps
// Busy timer and retry bookkeeping for the shared data-rate budget.
module bwm_throttle #(
  parameter int SIZE_W = 7,
  parameter int CPB_W  = 8,
  parameter int FRAC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [SIZE_W-1:0] size,
  input  logic [CPB_W-1:0]  cpb,
  input  logic              refuse,
  input  logic              room,
  output logic              busy,
  output logic              pend,
  output logic              retry
);
  localparam int PROD_W = SIZE_W + CPB_W;
  localparam int CNT_W  = PROD_W + 1 - FRAC;
  localparam logic [PROD_W:0] RND = (PROD_W+1)'((1 << FRAC) - 1);

  logic [PROD_W:0]  prod;
  logic [CNT_W-1:0] dur, cnt_q;
  logic             fire;

  // size * factor, rounded up to whole cycles
  assign prod = ({{(CPB_W+1){1'b0}}, size} * {{(SIZE_W+1){1'b0}}, cpb}) + RND;
  assign dur  = prod[PROD_W:FRAC];
  assign busy = (cnt_q != '0);
  assign fire = pend && !busy && room;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pend  <= 1'b0;
      retry <= 1'b0;
    end else begin
      retry <= 1'b0;
      if (start)      cnt_q <= dur;
      else if (busy)  cnt_q <= cnt_q - 1'b1;
      if (fire) begin
        pend  <= 1'b0;
        retry <= 1'b1;
      end else if (refuse) begin
        pend  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bwm_ram.sv
`timescale 1ns/1ps
// Single-port RAM with registered read, in a form block RAM can take.
module bwm_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bwm_rspq.sv
`timescale 1ns/1ps
// In-order response queue; the head leaves only once its due time is reached.
module bwm_rspq import bwm_pkg::*; #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64,
  parameter int TIME_W = 16,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  op_e               push_op,
  input  logic [DATA_W-1:0] push_data,
  input  logic [TIME_W-1:0] push_due,
  input  logic [TIME_W-1:0] now,
  input  logic              ready,
  output logic              valid,
  output op_e               head_op,
  output logic [DATA_W-1:0] head_data,
  output logic [CW-1:0]     count
);
  op_e               op_m   [DEPTH];
  logic [DATA_W-1:0] data_m [DEPTH];
  logic [TIME_W-1:0] due_m  [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [TIME_W-1:0] slack;
  logic              pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // wrap-safe: due when now - due is not negative
  assign slack     = now - due_m[rd_ptr];
  assign valid     = (count != '0) && !slack[TIME_W-1];
  assign head_op   = op_m[rd_ptr];
  assign head_data = data_m[rd_ptr];
  assign pop       = valid && ready;

  always_ff @(posedge clk) begin
    if (push) begin
      op_m[wr_ptr]   <= push_op;
      data_m[wr_ptr] <= push_data;
      due_m[wr_ptr]  <= push_due;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/bw_mem_target.sv
`timescale 1ns/1ps
module bw_mem_target import bwm_pkg::*; #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 64,
  parameter int SIZE_W   = 7,
  parameter int CPB_W    = 8,
  parameter int CPB_FRAC = 4,
  parameter int LAT_W    = 8,
  parameter int QDEPTH   = 4,
  parameter int TIME_W   = 16,
  parameter int MIN_LAT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_accept,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CPB_W-1:0]  cfg_cpb,
  input  logic [LAT_W-1:0]  cfg_lat,
  output logic              retry,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_op,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int QCW = $clog2(QDEPTH + 1);

  op_e               req_kind, s1_op, q_op;
  logic              busy, pend, room, acc, refuse, start, needs_rsp, wr_en;
  logic              s1_vld;
  logic [TIME_W-1:0] now_q, due_d, s1_due;
  logic [LAT_W-1:0]  lat_eff;
  logic [DATA_W-1:0] ram_rd, push_data;
  logic [QCW-1:0]    q_count;
  logic [QCW:0]      used;

  assign req_kind   = op_e'(req_op);
  assign used       = {1'b0, q_count} + (QCW+1)'(s1_vld);
  assign room       = used < (QCW+1)'(QDEPTH);
  assign req_accept = !busy && !pend && room;
  assign acc        = req_valid && req_accept;
  assign refuse     = req_valid && !req_accept;
  assign start      = acc && (req_kind != OP_CMD);
  assign needs_rsp  = (req_kind != OP_POST);
  assign wr_en      = acc && ((req_kind == OP_WRITE) || (req_kind == OP_POST));
  assign lat_eff    = (cfg_lat < LAT_W'(MIN_LAT)) ? LAT_W'(MIN_LAT) : cfg_lat;
  assign due_d      = now_q + TIME_W'(lat_eff);

  bwm_throttle #(.SIZE_W(SIZE_W), .CPB_W(CPB_W), .FRAC(CPB_FRAC)) u_thr (
    .clk(clk), .rst(rst), .start(start), .size(req_size), .cpb(cfg_cpb),
    .refuse(refuse), .room(room), .busy(busy), .pend(pend), .retry(retry)
  );

  bwm_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(wr_en), .addr(req_addr), .wdata(req_wdata), .rdata(ram_rd)
  );

  // stage 1: wait for the registered RAM read, then enqueue
  always_ff @(posedge clk) begin
    if (rst) begin
      now_q  <= '0;
      s1_vld <= 1'b0;
      s1_op  <= OP_READ;
      s1_due <= '0;
    end else begin
      now_q  <= now_q + 1'b1;
      s1_vld <= acc && needs_rsp;
      if (acc) begin
        s1_op  <= req_kind;
        s1_due <= due_d;
      end
    end
  end

  assign push_data = (s1_op == OP_READ) ? ram_rd : '0;

  bwm_rspq #(.DEPTH(QDEPTH), .DATA_W(DATA_W), .TIME_W(TIME_W)) u_q (
    .clk(clk), .rst(rst), .push(s1_vld), .push_op(s1_op), .push_data(push_data),
    .push_due(s1_due), .now(now_q), .ready(rsp_ready), .valid(rsp_valid),
    .head_op(q_op), .head_data(rsp_data), .count(q_count)
  );

  assign rsp_op = q_op;
endmodule

// File: rtl/bwm_chk.sv
`timescale 1ns/1ps
module bwm_chk #(
  parameter int SIZE_W = 7,
  parameter int CPB_W  = 8,
  parameter int QDEPTH = 4,
  parameter int DATA_W = 64,
  parameter int QCW    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_accept,
  input logic [1:0]        req_op,
  input logic [SIZE_W-1:0] req_size,
  input logic [CPB_W-1:0]  cfg_cpb,
  input logic              retry,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              busy,
  input logic              pend,
  input logic [QCW-1:0]    q_count
);
  // R2
  throttle_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_accept && req_op != 2'b11 && cfg_cpb != '0 && req_size != '0)
      |=> !req_accept);
  // R4
  cmd_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_accept && req_op == 2'b11 && !busy) |=> !busy);
  // R5
  refuse_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_accept) |=> (!req_accept || retry));
  // R6
  retry_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    retry |=> !retry);
  // R6
  retry_accept_chk: assert property (@(posedge clk) disable iff (rst)
    retry |-> (req_accept && !pend));
  // R9
  head_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    q_count <= QCW'(QDEPTH));
endmodule

bind bw_mem_target bwm_chk #(
  .SIZE_W(SIZE_W), .CPB_W(CPB_W), .QDEPTH(QDEPTH), .DATA_W(DATA_W), .QCW(QCW)
) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_accept(req_accept),
  .req_op(req_op), .req_size(req_size), .cfg_cpb(cfg_cpb), .retry(retry),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .busy(busy), .pend(pend), .q_count(q_count)
);

// File: tb/test_bw_mem_target.sv
`timescale 1ns/1ps
module test_bw_mem_target;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_accept;
  logic [1:0]  req_op = 2'b00;
  logic [5:0]  req_addr = '0;
  logic [6:0]  req_size = 7'd1;
  logic [63:0] req_wdata = '0;
  logic [7:0]  cfg_cpb = '0;
  logic [7:0]  cfg_lat = 8'd2;
  logic        retry, rsp_valid, rsp_ready;
  logic [1:0]  rsp_op;
  logic [63:0] rsp_data;

  int checks = 0, errors = 0, cyc = 0, acc_cyc = 0;
  int nlog = 0;
  logic [63:0] log_d [16];
  bit done = 0;

  bw_mem_target i_bw_mem_target (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_accept(req_accept),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .cfg_cpb(cfg_cpb), .cfg_lat(cfg_lat), .retry(retry), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_op(rsp_op), .rsp_data(rsp_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk)
    if (!rst && rsp_valid && rsp_ready && nlog < 16) begin
      log_d[nlog] = rsp_data;
      nlog++;
    end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // offer one request and return just after the accepting edge
  task automatic send(input logic [1:0] op, input logic [5:0] a, input logic [6:0] sz,
                      input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_size = sz; req_wdata = d;
    while (!req_accept) @(negedge clk);
    @(posedge clk);
    acc_cyc = cyc;
    #1 req_valid = 1'b0;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (req_accept) break;
      n++;
      if (n > 2000) break;
    end
  endtask

  task automatic wait_rsp(output int k);
    k = 0;
    forever begin
      @(negedge clk);
      k++;
      if (rsp_valid || k > 300) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(req_accept === 1'b1, "R10 accept", req_accept, 1);
    check(retry === 1'b0 && rsp_valid === 1'b0, "R10 retry/rsp idle", {retry, rsp_valid}, 0);
  endtask

  task automatic t_latency();
    int k;
    cfg_cpb = 0; cfg_lat = 8'd5;
    send(2'b01, 6'd3, 7'd8, 64'hDEAD_BEEF_0123_4567);
    @(negedge clk);
    check(req_accept === 1'b1, "R3 zero factor no stall", req_accept, 1);
    wait_rsp(k);
    check(k == 4, "R7 write ack latency (accept test offset)", k, 4);
    check(rsp_op == 2'b01 && rsp_data == 0, "R7 write ack data zero", rsp_data, 0);
    send(2'b00, 6'd3, 7'd8, 64'h0);
    wait_rsp(k);
    check(k == 5, "R7 latency 5", k, 5);
    check(rsp_data == 64'hDEAD_BEEF_0123_4567, "R7 read data", rsp_data, 64'hDEAD_BEEF_0123_4567);
    cfg_lat = 8'd0;
    send(2'b00, 6'd3, 7'd8, 64'h0);
    wait_rsp(k);
    check(k == 2, "R7 latency floor 2", k, 2);
    cfg_lat = 8'd2;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_throttle();
    int n;
    cfg_cpb = 8'd16;
    send(2'b00, 6'd1, 7'd8, 0); count_stall(n);
    check(n == 8, "R2 cpb 1.0 size 8", n, 8);
    cfg_cpb = 8'h18;
    send(2'b00, 6'd1, 7'd5, 0); count_stall(n);
    check(n == 8, "R2 cpb 1.5 size 5 rounds up", n, 8);
    cfg_cpb = 8'd1;
    send(2'b00, 6'd1, 7'd1, 0); count_stall(n);
    check(n == 1, "R2 smallest factor", n, 1);
    cfg_cpb = 8'd255;
    send(2'b00, 6'd1, 7'd64, 0); count_stall(n);
    check(n == 1020, "R2 largest factor and size", n, 1020);
    cfg_cpb = 8'd16;
    send(2'b01, 6'd2, 7'd4, 64'h5); count_stall(n);
    check(n == 4, "R1 acked write shares budget", n, 4);
    send(2'b10, 6'd2, 7'd4, 64'h6); count_stall(n);
    check(n == 4, "R1 posted write shares budget", n, 4);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_command();
    int k;
    cfg_cpb = 8'd16; cfg_lat = 8'd3;
    send(2'b11, 6'd0, 7'd8, 0);
    @(negedge clk);
    check(req_accept === 1'b1, "R4 command not throttled", req_accept, 1);
    wait_rsp(k);
    check(rsp_op == 2'b11 && rsp_data == 0, "R4 command response", {rsp_op, rsp_data[7:0]}, 10'h300);
    cfg_lat = 8'd2;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_retry();
    int n = 0;
    cfg_cpb = 8'd16;
    send(2'b00, 6'd1, 7'd4, 0);
    req_valid = 1'b1; req_op = 2'b00; req_size = 7'd4;
    forever begin
      @(negedge clk);
      if (req_accept) break;
      n++;
      if (n > 50) break;
    end
    check(n == 5, "R5 refused through pending cycle", n, 5);
    check(retry === 1'b1, "R6 retry with accept", retry, 1);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    check(retry === 1'b0, "R6 retry one cycle", retry, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_posted();
    int k;
    int seen = 0;
    cfg_cpb = 0;
    repeat (3) @(negedge clk);
    nlog = 0;
    send(2'b10, 6'd7, 7'd8, 64'h1234_5678);
    repeat (10) @(negedge clk);
    check(nlog == 0, "R8 posted write silent", nlog, 0);
    send(2'b00, 6'd7, 7'd8, 0);
    wait_rsp(k);
    check(rsp_data == 64'h1234_5678, "R8 posted data stored", rsp_data, 64'h1234_5678);
    repeat (3) @(negedge clk);
    seen = nlog;
    check(seen == 1, "R8 only read answered", seen, 1);
  endtask

  task automatic t_queue();
    bit ok;
    int n = 0;
    cfg_cpb = 0; cfg_lat = 8'd2;
    for (int i = 0; i < 5; i++) send(2'b01, 6'(11 + i), 7'd8, 64'hA0 + 64'(i));
    repeat (4) @(negedge clk);
    rsp_ready = 1'b0;
    nlog = 0;
    for (int i = 0; i < 4; i++) send(2'b00, 6'(11 + i), 7'd8, 0);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b00; req_addr = 6'd15;
    @(negedge clk);
    check(req_accept === 1'b0, "R9 full queue refuses", req_accept, 0);
    check(rsp_valid === 1'b1 && rsp_data == 64'hA0, "R9 head held", rsp_data, 64'hA0);
    rsp_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (req_accept) break;
      n++;
      if (n > 50) break;
    end
    check(retry === 1'b1, "R9 retry after space", retry, 1);
    @(posedge clk); #1 req_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(nlog == 5, "R9 response count", nlog, 5);
    ok = 1;
    for (int i = 0; i < 5; i++) if (log_d[i] != 64'hA0 + 64'(i)) ok = 0;
    check(ok, "R9 in-order responses", log_d[4], 64'hA4);
  endtask

  initial begin
    rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_latency();
    t_throttle();
    t_command();
    t_retry();
    t_posted();
    t_queue();
    finish_run();
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end
endmodule